// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the byte-wide, two-address register front end of an eight-line interrupt controller. Writes to the command address either start an initialisation sequence or carry one of two run-time command formats. Writes to the data address feed the follow-up initialisation words in order, and once initialisation is over they load the mask register. The block holds the vector base, the operating mode flags and the mask. It forwards priority commands to an external priority resolver as one-cycle strobes.

Reads return the resolver's pending or in-service bits, or the mask. A one-shot poll mode makes the next read return the number of the winning line. The resolver provides the pending bits, the in-service bits and the current winning line. This block does no priority arithmetic. It forms the acknowledge vector from the vector base and the winning line, and reports line 7 as spurious when no line is pending.

Top module: `irq_prog_seq`

## Requirements
- R1: After synchronous reset the mask is 0, all mode flags (nested, auto-EOI, rotate-on-auto-EOI, special mask, read-select, poll) are 0, the sequencer is idle (`init_busy`=0), and `cmd_stb`, `init_clr` and `poll_clr` are 0.
- R2: A command-address write (`addr`=0) with bit 4 set clears the mask, every mode flag and the vector base, latches bit 0 as "mode word expected", and sets `init_busy`. `init_clr` is high for the one cycle after that write.
- R3: The first data-address write after initialisation starts stores bits 7:3 as the vector base. Bits 2:0 are ignored.
- R4: The second data-address write ends initialisation (`init_busy`=0) when no mode word was requested. Otherwise the sequencer waits for a third word.
- R5: The third data-address write sets the nested flag from bit 4 and the auto-EOI flag from bit 1, then ends initialisation.
- R6: A data-address write loads the mask only when the sequencer is idle. The initialisation words leave the mask unchanged.
- R7: A command-address write with bit 3 set and bit 4 clear is a read-control command: when bit 1 is set, read-select is loaded from bit 0. An `addr`=0 read returns `serv_bits` when read-select is 1 and `pend_bits` when it is 0. An `addr`=1 read returns the mask.
- R8: In a read-control command, bit 6 set loads the special-mask flag from bit 5. With bit 6 clear the flag is kept.
- R9: Any other command-address write (bits 4 and 3 clear) carries a code in bits 7:5. Codes 0 and 4 load rotate-on-auto-EOI from bit 7 and raise no strobe. Code 2 does nothing. Codes 1, 3, 5, 6 and 7 raise `cmd_stb` for the cycle after the write, with `cmd_code` set to the code and `cmd_line` set to bits 2:0.
- R10: A read-control command with bit 2 set arms poll. The next read returns the winning line number (0 when none is valid), disarms poll, and for a valid line raises `poll_clr` with `poll_line` for the following cycle.
- R11: `vector_out` is the vector base in bits 7:3 with the winning line in bits 2:0. When no line is valid, bits 2:0 are 7 and `spurious` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| pend_bits | input | 8 | Pending bits from the resolver |
| serv_bits | input | 8 | In-service bits from the resolver |
| best_valid | input | 1 | Resolver has a winning line |
| best_line | input | 3 | Winning line number |
| mask_bits | output | 8 | Mask register |
| nest_mode | output | 1 | Special fully nested flag |
| auto_eoi | output | 1 | Automatic end-of-interrupt flag |
| rot_auto_eoi | output | 1 | Rotate-on-auto-EOI flag |
| spec_mask | output | 1 | Special-mask flag |
| init_busy | output | 1 | Initialisation sequence in progress |
| init_clr | output | 1 | One-cycle pulse: resolver must clear its state |
| cmd_stb | output | 1 | One-cycle priority command strobe |
| cmd_code | output | 3 | Command code carried by the strobe |
| cmd_line | output | 3 | Line operand carried by the strobe |
| poll_clr | output | 1 | One-cycle pulse: clear pending and in-service bits of `poll_line` |
| poll_line | output | 3 | Line taken by the poll read |
| vector_out | output | 8 | Acknowledge vector |
| spurious | output | 1 | No valid line at acknowledge |

## Verification
The checker watches several rules on every cycle. The mask never changes unless a write was issued in the previous cycle. A command strobe only ever carries one of the five strobing codes and always follows a command-address write. A poll clear pulse always follows a read. An initialisation clear pulse always coincides with a busy sequencer. The vector's low bits read 7 whenever the resolver has no winner. The bench scenarios cover the properties that depend on order. These are the number of initialisation words with and without the mode word, a mask write being ignored during the sequence, flags kept when their enable bits are clear, and the one-shot nature of poll.

// File: rtl/psq_pkg.sv
// Shared types for the programming sequencer.
// Assumes an 8-line controller driven through a byte-wide port.
package psq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        WK_INIT  = 2'd0,
        WK_RDCTL = 2'd1,
        WK_PRIO  = 2'd2
    } wr_kind_t;
endpackage

// File: rtl/psq_decode.sv
// Classifies a command-address byte into initialisation start, read-control
// command or priority command, and extracts the priority code.
// Purely combinational; assumes the byte layout fixed in the requirements.
module psq_decode #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_in,
    output psq_pkg::wr_kind_t kind,
    output logic [2:0]        code,
    output logic              strobing
);
    // Format selection: bit 4 wins over bit 3
    always_comb begin
        if (byte_in[4])      kind = psq_pkg::WK_INIT;
        else if (byte_in[3]) kind = psq_pkg::WK_RDCTL;
        else                 kind = psq_pkg::WK_PRIO;
    end

    // Code field and whether it produces a resolver strobe
    always_comb begin
        code = byte_in[7:5];
        case (byte_in[7:5])
            3'd1, 3'd3, 3'd5, 3'd6, 3'd7: strobing = 1'b1;
            default:                      strobing = 1'b0;
        endcase
    end
endmodule

// File: rtl/psq_init_fsm.sv
// Steps through the data-address words that follow an initialisation start.
// Emits single-cycle take strobes for the base word and the mode word.
// Assumes start and data writes never arrive in the same cycle from software.
module psq_init_fsm (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 want_mode,
    input  logic                 data_wr,
    output psq_pkg::seq_state_t  state,
    output logic                 take_base,
    output logic                 take_mode
);
    import psq_pkg::*;

    logic want_mode_q;

    // Sequence state and latched mode-word request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            want_mode_q <= 1'b0;
        end else if (start) begin
            state       <= SEQ_BASE;
            want_mode_q <= want_mode;
        end else if (data_wr) begin
            case (state)
                SEQ_BASE: state <= SEQ_CASC;
                SEQ_CASC: state <= want_mode_q ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // Take strobes for the word written in the current state
    always_comb begin
        take_base = data_wr && !start && (state == SEQ_BASE);
        take_mode = data_wr && !start && (state == SEQ_MODE);
    end
endmodule

// File: rtl/irq_prog_seq.sv
// Register front end of an 8-line interrupt controller: decodes command and
// data writes, holds base, mask and mode flags, serves reads and poll, and
// strobes priority commands to an external resolver.
// Assumes the resolver supplies pending/in-service bits and the winning line.
module irq_prog_seq #(
    parameter int DATA_W = 8,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pend_bits,
    input  logic [DATA_W-1:0] serv_bits,
    input  logic              best_valid,
    input  logic [LINE_W-1:0] best_line,
    output logic [DATA_W-1:0] mask_bits,
    output logic              nest_mode,
    output logic              auto_eoi,
    output logic              rot_auto_eoi,
    output logic              spec_mask,
    output logic              init_busy,
    output logic              init_clr,
    output logic              cmd_stb,
    output logic [2:0]        cmd_code,
    output logic [LINE_W-1:0] cmd_line,
    output logic              poll_clr,
    output logic [LINE_W-1:0] poll_line,
    output logic [DATA_W-1:0] vector_out,
    output logic              spurious
);
    import psq_pkg::*;

    localparam int BASE_W = DATA_W - LINE_W;
    localparam logic [LINE_W-1:0] SPUR_LINE = {LINE_W{1'b1}};

    wr_kind_t           kind;
    logic [2:0]         code;
    logic               strobing;
    seq_state_t         state;
    logic               take_base;
    logic               take_mode;
    logic               cmd_wr;
    logic               data_wr;
    logic               start;
    logic               rd_sel;
    logic               poll_armed;
    logic [BASE_W-1:0]  base_q;

    assign cmd_wr  = wr_en && !addr;
    assign data_wr = wr_en && addr;
    assign start   = cmd_wr && (kind == WK_INIT);

    psq_decode #(.DATA_W(DATA_W)) u_dec (
        .byte_in  (wdata),
        .kind     (kind),
        .code     (code),
        .strobing (strobing)
    );

    psq_init_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .want_mode (wdata[0]),
        .data_wr   (data_wr),
        .state     (state),
        .take_base (take_base),
        .take_mode (take_mode)
    );

    assign init_busy = (state != SEQ_IDLE);

    // Registers, mode flags and one-cycle resolver strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_bits    <= '0;
            base_q       <= '0;
            nest_mode    <= 1'b0;
            auto_eoi     <= 1'b0;
            rot_auto_eoi <= 1'b0;
            spec_mask    <= 1'b0;
            rd_sel       <= 1'b0;
            poll_armed   <= 1'b0;
            init_clr     <= 1'b0;
            cmd_stb      <= 1'b0;
            cmd_code     <= '0;
            cmd_line     <= '0;
            poll_clr     <= 1'b0;
            poll_line    <= '0;
        end else begin
            init_clr <= 1'b0;
            cmd_stb  <= 1'b0;
            poll_clr <= 1'b0;
            if (rd_en && poll_armed) begin
                poll_armed <= 1'b0;
                poll_clr   <= best_valid;
                poll_line  <= best_line;
            end
            if (cmd_wr) begin
                case (kind)
                    WK_INIT: begin
                        mask_bits    <= '0;
                        base_q       <= '0;
                        nest_mode    <= 1'b0;
                        auto_eoi     <= 1'b0;
                        rot_auto_eoi <= 1'b0;
                        spec_mask    <= 1'b0;
                        rd_sel       <= 1'b0;
                        poll_armed   <= 1'b0;
                        init_clr     <= 1'b1;
                    end
                    WK_RDCTL: begin
                        if (wdata[2]) poll_armed <= 1'b1;
                        if (wdata[1]) rd_sel     <= wdata[0];
                        if (wdata[6]) spec_mask  <= wdata[5];
                    end
                    default: begin
                        if (code[1:0] == 2'b00) rot_auto_eoi <= wdata[7];
                        if (strobing) begin
                            cmd_stb  <= 1'b1;
                            cmd_code <= code;
                            cmd_line <= wdata[LINE_W-1:0];
                        end
                    end
                endcase
            end
            if (data_wr) begin
                if (state == SEQ_IDLE) mask_bits <= wdata;
                if (take_base) base_q <= wdata[DATA_W-1:LINE_W];
                if (take_mode) begin
                    nest_mode <= wdata[4];
                    auto_eoi  <= wdata[1];
                end
            end
        end
    end

    // Read data: poll result, status select, or mask
    always_comb begin
        if (poll_armed)
            rdata = best_valid ? DATA_W'(best_line) : '0;
        else if (addr)
            rdata = mask_bits;
        else
            rdata = rd_sel ? serv_bits : pend_bits;
    end

    // Acknowledge vector with spurious substitution
    always_comb begin
        spurious   = !best_valid;
        vector_out = {base_q, best_valid ? best_line : SPUR_LINE};
    end
endmodule

// File: rtl/irq_prog_seq_chk.sv
// Cycle rules for irq_prog_seq, attached through bind.
// Assumes the DUT's port names and 8-bit / 3-bit default widths.
module irq_prog_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] mask_bits,
    input logic       init_busy,
    input logic       init_clr,
    input logic       cmd_stb,
    input logic [2:0] cmd_code,
    input logic       poll_clr,
    input logic       best_valid,
    input logic [7:0] vector_out
);
    logic seen_clk;

    // Marks that at least one edge has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen_clk <= 1'b0;
        else        seen_clk <= 1'b1;
    end

    // R6
    mask_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
        !$stable(mask_bits) |-> $past(wr_en));

    // R2
    init_clr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |-> init_busy);

    // R9
    cmd_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (cmd_code != 3'd0 && cmd_code != 3'd2 && cmd_code != 3'd4));

    // R9
    cmd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
        cmd_stb |-> $past(wr_en && !addr));

    // R10
    poll_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen_clk)
        poll_clr |-> $past(rd_en));

    // R11
    spurious_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid |-> vector_out[2:0] == 3'd7);
endmodule

bind irq_prog_seq irq_prog_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .mask_bits  (mask_bits),
    .init_busy  (init_busy),
    .init_clr   (init_clr),
    .cmd_stb    (cmd_stb),
    .cmd_code   (cmd_code),
    .poll_clr   (poll_clr),
    .best_valid (best_valid),
    .vector_out (vector_out)
);

// File: tb/tb_irq_prog_seq.sv
// Directed bench for irq_prog_seq: one task per scenario.
module tb_irq_prog_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pend_bits = '0, serv_bits = '0;
    logic       best_valid = 1'b0;
    logic [2:0] best_line = '0;
    logic [7:0] mask_bits;
    logic       nest_mode, auto_eoi, rot_auto_eoi, spec_mask, init_busy, init_clr;
    logic       cmd_stb, poll_clr, spurious;
    logic [2:0] cmd_code, cmd_line, poll_line;
    logic [7:0] vector_out;
    int         n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    irq_prog_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pend_bits(pend_bits), .serv_bits(serv_bits),
        .best_valid(best_valid), .best_line(best_line), .mask_bits(mask_bits),
        .nest_mode(nest_mode), .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi),
        .spec_mask(spec_mask), .init_busy(init_busy), .init_clr(init_clr),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_line(cmd_line),
        .poll_clr(poll_clr), .poll_line(poll_line), .vector_out(vector_out),
        .spurious(spurious)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 mask", mask_bits, 8'h00);
        chk("R1 busy", {7'd0, init_busy}, 8'h00);
        chk("R1 flags", {4'd0, nest_mode, auto_eoi, rot_auto_eoi, spec_mask}, 8'h00);
        chk("R1 strobes", {5'd0, cmd_stb, init_clr, poll_clr}, 8'h00);
        rd(1'b1, v);
        chk("R1 mask read", v, 8'h00);
    endtask

    task automatic t_init_short();
        wr(1'b1, 8'h5A);
        wr(1'b0, 8'h10);
        chk("R2 init_clr", {7'd0, init_clr}, 8'h01);
        chk("R2 busy", {7'd0, init_busy}, 8'h01);
        chk("R2 mask cleared", mask_bits, 8'h00);
        wr(1'b1, 8'h4D);
        chk("R2 init_clr one cycle", {7'd0, init_clr}, 8'h00);
        chk("R6 base word not mask", mask_bits, 8'h00);
        best_valid = 1'b1; best_line = 3'd3; #1;
        chk("R3 base low bits ignored", vector_out, 8'h4B);
        wr(1'b1, 8'h77);
        chk("R4 short sequence ends", {7'd0, init_busy}, 8'h00);
        chk("R6 cascade word not mask", mask_bits, 8'h00);
    endtask

    task automatic t_init_long();
        logic [7:0] v;
        wr(1'b1, 8'hA5);
        rd(1'b1, v);
        chk("R6 mask load", v, 8'hA5);
        wr(1'b0, 8'h11);
        chk("R2 mask cleared by init", mask_bits, 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'hFF);
        chk("R4 waits for mode word", {7'd0, init_busy}, 8'h01);
        chk("R6 mask kept during init", mask_bits, 8'h00);
        wr(1'b1, 8'h12);
        chk("R5 done", {7'd0, init_busy}, 8'h00);
        chk("R5 nested", {7'd0, nest_mode}, 8'h01);
        chk("R5 auto eoi", {7'd0, auto_eoi}, 8'h01);
        wr(1'b1, 8'h3C);
        chk("R6 mask after init", mask_bits, 8'h3C);
    endtask

    task automatic t_readsel();
        logic [7:0] v;
        pend_bits = 8'h31; serv_bits = 8'h04;
        rd(1'b0, v); chk("R7 pending default", v, 8'h31);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R7 in-service", v, 8'h04);
        wr(1'b0, 8'h08);
        rd(1'b0, v); chk("R7 select kept", v, 8'h04);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R7 pending again", v, 8'h31);
        rd(1'b1, v); chk("R7 mask read", v, 8'h3C);
    endtask

    task automatic t_smask();
        wr(1'b0, 8'h68); chk("R8 set", {7'd0, spec_mask}, 8'h01);
        wr(1'b0, 8'h08); chk("R8 kept", {7'd0, spec_mask}, 8'h01);
        wr(1'b0, 8'h48); chk("R8 clear", {7'd0, spec_mask}, 8'h00);
    endtask

    task automatic t_cmds();
        wr(1'b0, 8'h20); chk("R9 code1", {4'd0, cmd_stb, cmd_code}, 8'h09);
        wr(1'b0, 8'h63); chk("R9 code3", {cmd_stb, cmd_code, 1'b0, cmd_line}, 8'hB3);
        wr(1'b0, 8'hE5); chk("R9 code7", {cmd_stb, cmd_code, 1'b0, cmd_line}, 8'hF5);
        wr(1'b0, 8'hC2); chk("R9 code6", {cmd_stb, cmd_code, 1'b0, cmd_line}, 8'hE2);
        wr(1'b0, 8'hA0); chk("R9 code5", {4'd0, cmd_stb, cmd_code}, 8'h0D);
        wr(1'b0, 8'h80);
        chk("R9 code4 rotate", {7'd0, rot_auto_eoi}, 8'h01);
        chk("R9 code4 no strobe", {7'd0, cmd_stb}, 8'h00);
        wr(1'b0, 8'h00);
        chk("R9 code0 rotate off", {7'd0, rot_auto_eoi}, 8'h00);
        wr(1'b0, 8'h40);
        chk("R9 code2 no strobe", {7'd0, cmd_stb}, 8'h00);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        best_valid = 1'b1; best_line = 3'd6;
        wr(1'b0, 8'h0C);
        rd(1'b0, v);
        chk("R10 poll line", v, 8'h06);
        chk("R10 poll clear", {poll_clr, 4'd0, poll_line}, 8'h86);
        rd(1'b0, v);
        chk("R10 one shot", v, 8'h31);
        chk("R10 no second clear", {7'd0, poll_clr}, 8'h00);
        best_valid = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b0, v);
        chk("R10 poll none", v, 8'h00);
        chk("R10 no clear when none", {7'd0, poll_clr}, 8'h00);
    endtask

    task automatic t_vector();
        best_valid = 1'b0; #1;
        chk("R11 spurious vector", vector_out, 8'h27);
        chk("R11 spurious flag", {7'd0, spurious}, 8'h01);
        best_valid = 1'b1; best_line = 3'd1; #1;
        chk("R11 vector", vector_out, 8'h21);
        chk("R11 not spurious", {7'd0, spurious}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_short();
        t_init_long();
        t_readsel();
        t_smask();
        t_cmds();
        t_poll();
        t_vector();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule